// File: doc/BRIEF.md
# Asymmetric Line Glitch Filter

This block cleans a single open-drain bus line before a receiver decodes it. The raw pin level is first brought into the system clock domain through a flop synchronizer. It is then examined only on cycles where a one-cycle sampling strobe is high. The filtered level moves to a new value only after enough consecutive samples at that value have been seen. Anything shorter is treated as a glitch and discarded.

The number of agreeing samples needed is set separately for each direction. A 3-bit field sets the count for a high-to-low change and a 2-bit field sets the count for a low-to-high change. In each case the number of samples needed is the field value plus one. Alongside the filtered level, the block gives single-cycle pulses that mark each accepted falling and rising edge. A receiver can use these pulses to time bits without detecting edges itself.

Top module: `line_glitch_filter`

## Requirements
- R1: On cycles where `sample_en` is low, `line_filt` and the internal run count do not change, and neither edge pulse is raised.
- R2: When `line_filt` is 1, it becomes 0 on the sampling tick that sees the (`lo_count`+1)-th consecutive low sample. `lo_count` is 3 bits, so 1 to 8 samples can be required.
- R3: When `line_filt` is 0, it becomes 1 on the sampling tick that sees the (`hi_count`+1)-th consecutive high sample. `hi_count` is 2 bits, so 1 to 4 samples can be required.
- R4: A run of samples opposite to `line_filt` that is shorter than the required count leaves `line_filt` unchanged and raises no pulse.
- R5: With `hi_count` = 2'b10 and `lo_count` = 3'b011, a filtered 1 falls on the fourth consecutive low sample, and a filtered 0 rises on the third consecutive high sample.
- R6: Any sample equal to the current `line_filt` clears the run count, so only an uninterrupted run can cause a change.
- R7: While `rst_n` is low, `line_filt` is 1, the run count is zero and both pulses are low.
- R8: A sampling tick uses the level `line_raw` had two clock edges earlier. A change made one cycle before the tick is not yet seen by that tick.
- R9: `fall_pulse` (or `rise_pulse`) is high for exactly the one cycle in which `line_filt` goes from 1 to 0 (or from 0 to 1). The two pulses are never high together.
- R10: A new value in `lo_count` or `hi_count` does not change `line_filt` on its own and takes effect at the next tick. If the run already recorded meets the new, shorter requirement, that next disagreeing tick accepts the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_raw | input | 1 | Raw bus line level, asynchronous to `clk` |
| sample_en | input | 1 | One-cycle sampling tick |
| lo_count | input | 3 | Low samples needed for a falling change, minus one |
| hi_count | input | 2 | High samples needed for a rising change, minus one |
| line_filt | output | 1 | Filtered line level |
| fall_pulse | output | 1 | One-cycle pulse on an accepted falling change |
| rise_pulse | output | 1 | One-cycle pulse on an accepted rising change |

## Verification
The filter is driven with runs that fall one sample short of the required length, which tells a noise rejection apart from an off-by-one acceptance. It is also driven with runs broken by one matching sample, which shows whether the run count really clears instead of simply pausing. Both count fields are tried at their minimum, their maximum and the default asymmetric pair, so that each direction's count is checked independently of the other. The counts are also shortened in the middle of a run, and a raw change is placed one cycle before a tick, to pin down when new settings and new line levels take effect.

// File: rtl/lgf_pkg.sv
`timescale 1ns/1ps
package lgf_pkg;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_RISE = 2'b10
   } edge_e;

   function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lgf_sync.sv
`timescale 1ns/1ps
module lgf_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("lgf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/lgf_run_ctr.sv
`timescale 1ns/1ps
module lgf_run_ctr
   import lgf_pkg::*;
#(
   parameter int   LO_W      = 3,
   parameter int   HI_W      = 2,
   parameter logic RST_LEVEL = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic            smp_i,
   input  logic [LO_W-1:0] lo_need_i,
   input  logic [HI_W-1:0] hi_need_i,
   output logic            level_o,
   output edge_e           edge_o
);

   localparam int CNT_W = max_w(LO_W, HI_W);

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] limit;
   logic             level_q;
   edge_e            edge_q;

   // Limit is the required count minus one, taken from the direction a change would go.
   always_comb begin
      limit = level_q ? CNT_W'(lo_need_i) : CNT_W'(hi_need_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= RST_LEVEL;
         run_q   <= '0;
         edge_q  <= EDGE_NONE;
      end else begin
         edge_q <= EDGE_NONE;
         if (tick_i) begin
            if (smp_i == level_q) begin
               run_q <= '0;
            end else if (run_q >= limit) begin
               level_q <= smp_i;
               run_q   <= '0;
               edge_q  <= smp_i ? EDGE_RISE : EDGE_FALL;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   end

   assign level_o = level_q;
   assign edge_o  = edge_q;

   a_r1_level_holds_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(level_q));

   a_r1_run_holds_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(run_q));

   a_r6_match_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && (smp_i == level_q)) |=> (run_q == '0) && $stable(level_q));

   a_r4_change_needs_disagreeing_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q != $past(level_q)) |-> $past(tick_i && (smp_i != level_q)));

   a_r9_fall_tracks_level: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_q == EDGE_FALL) |-> (!level_q && $past(level_q)));

   a_r9_rise_tracks_level: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_q == EDGE_RISE) |-> (level_q && !$past(level_q)));

endmodule

// File: rtl/lgf_edge_dec.sv
`timescale 1ns/1ps
module lgf_edge_dec
   import lgf_pkg::*;
(
   input  edge_e edge_i,
   output logic  fall_o,
   output logic  rise_o
);

   always_comb begin
      fall_o = (edge_i == EDGE_FALL);
      rise_o = (edge_i == EDGE_RISE);
   end

endmodule

// File: rtl/line_glitch_filter.sv
`timescale 1ns/1ps
module line_glitch_filter
   import lgf_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter int   LO_W        = 3,
   parameter int   HI_W        = 2,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            line_raw,
   input  logic            sample_en,
   input  logic [LO_W-1:0] lo_count,
   input  logic [HI_W-1:0] hi_count,
   output logic            line_filt,
   output logic            fall_pulse,
   output logic            rise_pulse
);

   generate
      if (LO_W < 1 || LO_W > 16) begin : g_bad_lo
         $error("line_glitch_filter: LO_W out of range");
      end
      if (HI_W < 1 || HI_W > 16) begin : g_bad_hi
         $error("line_glitch_filter: HI_W out of range");
      end
   endgenerate

   logic  line_sync;
   edge_e edge_w;

   lgf_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IDLE_LEVEL)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (line_raw),
      .q_o   (line_sync)
   );

   lgf_run_ctr #(
      .LO_W      (LO_W),
      .HI_W      (HI_W),
      .RST_LEVEL (IDLE_LEVEL)
   ) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (sample_en),
      .smp_i     (line_sync),
      .lo_need_i (lo_count),
      .hi_need_i (hi_count),
      .level_o   (line_filt),
      .edge_o    (edge_w)
   );

   lgf_edge_dec u_edge (
      .edge_i (edge_w),
      .fall_o (fall_pulse),
      .rise_o (rise_pulse)
   );

   a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fall_pulse, rise_pulse}));

   a_r1_no_pulse_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_en |=> !(fall_pulse || rise_pulse));

   a_r9_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_pulse || rise_pulse) |=> !(fall_pulse || rise_pulse));

endmodule

// File: tb/line_glitch_filter_test.sv
`timescale 1ns/1ps
module line_glitch_filter_test;

   localparam int WATCHDOG_CYCLES = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_raw = 1'b1;
   logic       sample_en = 1'b0;
   logic [2:0] lo_count = 3'b011;
   logic [1:0] hi_count = 2'b10;
   logic       line_filt, fall_pulse, rise_pulse;

   int n_cmp = 0;
   int n_bad = 0;

   logic       m_lvl = 1'b1;
   int         m_run = 0;
   logic       m_fall, m_rise;
   logic       last_filt = 1'b1;
   logic       pend = 1'b0;
   logic       mon_on = 1'b0;
   logic [2:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   line_glitch_filter uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_raw   (line_raw),
      .sample_en  (sample_en),
      .lo_count   (lo_count),
      .hi_count   (hi_count),
      .line_filt  (line_filt),
      .fall_pulse (fall_pulse),
      .rise_pulse (rise_pulse)
   );

   task automatic model(input logic seen);
      int need;
      m_fall = 1'b0;
      m_rise = 1'b0;
      need = m_lvl ? (int'(lo_count) + 1) : (int'(hi_count) + 1);
      if (seen == m_lvl) begin
         m_run = 0;
      end else if (m_run + 1 >= need) begin
         m_lvl = seen;
         m_run = 0;
         m_fall = ~seen;
         m_rise = seen;
      end else begin
         m_run = m_run + 1;
      end
   endtask

   // Called just after a negedge; gap is the number of negedges between the raw change and the strobe.
   task automatic do_tick(input logic v, input int gap, input string tag);
      logic seen;
      seen = (gap >= 2) ? v : line_raw;
      line_raw = v;
      repeat (gap) @(negedge clk);
      model(seen);
      exp_q.push_back({m_lvl, m_fall, m_rise});
      tag_q.push_back(tag);
      sample_en = 1'b1;
      @(negedge clk);
      sample_en = 1'b0;
   endtask

   task automatic run_of(input logic v, input int n, input string tag);
      for (int i = 0; i < n; i++) do_tick(v, 3, tag);
   endtask

   always @(posedge clk) pend <= sample_en;

   always @(negedge clk) begin
      if (mon_on) begin
         if (pend) begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if ({line_filt, fall_pulse, rise_pulse} !== e) begin
               n_bad++;
               $display("FAIL %s: filt/fall/rise got %b%b%b expected %b%b%b",
                        t, line_filt, fall_pulse, rise_pulse, e[2], e[1], e[0]);
            end
            last_filt = e[2];
         end else begin
            n_cmp++;
            if ({line_filt, fall_pulse, rise_pulse} !== {last_filt, 2'b00}) begin
               n_bad++;
               $display("FAIL R1 idle cycle: filt/fall/rise got %b%b%b expected %b00",
                        line_filt, fall_pulse, rise_pulse, last_filt);
            end
         end
      end
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      n_cmp++;
      if ({line_filt, fall_pulse, rise_pulse} !== 3'b100) begin
         n_bad++;
         $display("FAIL R7 reset: filt/fall/rise got %b%b%b expected 100",
                  line_filt, fall_pulse, rise_pulse);
      end
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      mon_on = 1'b1;

      // R5 / R4 / R6: default counts, short low run broken by a high sample
      run_of(1'b0, 3, "R4 short low run");
      do_tick(1'b1, 3, "R6 match clears run");
      run_of(1'b0, 3, "R6 restart low run");
      do_tick(1'b0, 3, "R5 fourth low falls");
      run_of(1'b1, 2, "R4 short high run");
      do_tick(1'b0, 3, "R6 match clears high run");
      run_of(1'b1, 2, "R6 restart high run");
      do_tick(1'b1, 3, "R5 third high rises");

      // R2 / R3 at minimum counts
      @(negedge clk); lo_count = 3'd0; hi_count = 2'd0;
      do_tick(1'b0, 3, "R2 single low sample");
      do_tick(1'b1, 3, "R3 single high sample");

      // R2 / R3 at maximum counts
      @(negedge clk); lo_count = 3'd7; hi_count = 2'd3;
      run_of(1'b0, 7, "R4 seven lows");
      do_tick(1'b1, 3, "R6 break at seven");
      run_of(1'b0, 7, "R2 lows below eight");
      do_tick(1'b0, 3, "R2 eighth low falls");
      run_of(1'b1, 3, "R3 highs below four");
      do_tick(1'b1, 3, "R3 fourth high rises");

      // R10: shorten counts in the middle of a run
      run_of(1'b0, 5, "R10 long run begins");
      repeat (2) @(negedge clk);
      lo_count = 3'd2;
      repeat (3) @(negedge clk);
      do_tick(1'b0, 3, "R10 shortened low count");
      run_of(1'b1, 2, "R10 high run begins");
      @(negedge clk); hi_count = 2'd0;
      repeat (3) @(negedge clk);
      do_tick(1'b1, 3, "R10 shortened high count");

      // R8: a change one cycle before a tick is not yet seen
      @(negedge clk); lo_count = 3'd0;
      repeat (4) @(negedge clk);
      do_tick(1'b0, 1, "R8 late change unseen");
      do_tick(1'b0, 3, "R8 settled change seen");
      do_tick(1'b1, 1, "R8 late rise unseen");
      do_tick(1'b1, 3, "R8 settled rise seen");

      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule